// File: doc/BRIEF.md
# Eight-Point Pipelined DCT Engine

This block computes a one-dimensional eight-point discrete cosine transform on a stream that delivers one sample every clock. A mode input picks the direction for each group of eight. In the forward direction the inputs are pixels and the outputs are coefficients. In the inverse direction the inputs are coefficients and the outputs are pixels. The arithmetic uses an even/odd butterfly factorisation. Seven signed cosine constants with a fixed number of fractional bits carry the multiplications.

A block-start strobe marks the first sample of a group. The sequencer restarts on every strobe. It gathers eight samples and then stops until the next strobe arrives. Groups can follow each other with no gap. The eight results leave in index order, one per clock, under a valid strobe. An output block-start pulse marks the first result of each group. The block serves as the row pass or the column pass of a two-dimensional transform.

Top module: `dct1d_top`

## Requirements
- R1: While reset is asserted and right after it is released, `validOut` and `blkStartOut` are low.
- R2: In forward mode (`invModeIn`=0) only the low PIX_W bits of `dataIn` are used, sign-extended. The higher bits have no effect. Result k is `0.5*c(k)*sum_n x[n]*cos((2n+1)k*pi/16)`, with c(0)=1/sqrt(2) and c(k)=1 otherwise. It is rounded, saturated to the signed DATA_W range, and exact to within 2 LSB.
- R3: The direction is taken only in the cycle that carries `blkStartIn`. Changing `invModeIn` during the other seven samples of a group has no effect on that group.
- R4: In inverse mode (`invModeIn`=1) all DATA_W input bits form a signed coefficient. Result n is `sum_k 0.5*c(k)*X[k]*cos((2n+1)k*pi/16)`. It is rounded, saturated to the signed PIX_W range, sign-extended onto `dataOut`, and exact to within 2 LSB.
- R5: If the first sample of a group is presented in cycle c, the eight results appear in cycles c+9 to c+16 in index order 0..7, with `validOut` high in exactly those cycles.
- R6: `blkStartOut` is high only together with the result of index 0 of each group.
- R7: Groups whose start strobes come eight cycles apart are all transformed, and their results follow each other with no idle cycle.
- R8: A start strobe that arrives before eight samples of a group have been taken abandons that group. The abandoned group produces no results, and the new group is processed normally.
- R9: Once eight samples have been taken, further samples presented without a start strobe are ignored. They produce no results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| blkStartIn | input | 1 | Marks the first sample of a group |
| invModeIn | input | 1 | Direction for the group starting this cycle: 0 forward, 1 inverse |
| dataIn | input | DATA_W | Sample, two's complement |
| blkStartOut | output | 1 | High with the first result of a group |
| validOut | output | 1 | Result on `dataOut` is valid |
| dataOut | output | DATA_W | Result, two's complement |

## Verification
The bench drives forward pixels whose spare upper bits carry garbage. A design that failed to sign-extend from the pixel width would return coefficients far off the reference. An inverse group has its mode line toggled after the start strobe. A design that looked at the mode every cycle would mix the two directions. Inverse groups with a very large DC term exercise saturation to the pixel range, which wrapping arithmetic would turn into wrong-signed pixels. Abandoned partial groups and trailing samples after a full group are also driven. A sequencer that failed to restart or to stop would emit extra or shifted result runs, and the cycle-by-cycle comparison of the valid strobe would catch them.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NPTS  = 8;
  localparam int IDX_W = $clog2(NPTS);

  // strobes from sequencer to datapath
  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] writeIdx;
    logic             blockLoad;
    logic             blockInv;
    logic             resLoad;
    logic             cmpInv;
    logic             outValid;
    logic             outInv;
    logic [IDX_W-1:0] outSel;
  } dctCtl_t;

  // 0.5*cos(k*pi/16) in Q16, reduced to fracW fractional bits (fracW < 16)
  function automatic int cosTap(input int k, input int fracW);
    int q16;
    case (k)
      1: q16 = 32139;
      2: q16 = 30273;
      3: q16 = 27245;
      4: q16 = 23170;
      5: q16 = 18205;
      6: q16 = 12540;
      7: q16 = 6393;
      default: q16 = 0;
    endcase
    return (q16 + (1 << (15 - fracW))) >>> (16 - fracW);
  endfunction
endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    blkStartIn,
  input  logic    invModeIn,
  output dctCtl_t ctl,
  output logic    blkStartOut,
  output logic    validOut
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPTS - 1);

  logic             inActive, curInv, cmpInv, outInv, resLoadQ, outActive;
  logic [IDX_W-1:0] inCnt, curIdx, outCnt;
  logic             takeSample, lastSample;

  assign curIdx     = blkStartIn ? '0 : inCnt;
  assign takeSample = blkStartIn | inActive;
  assign lastSample = takeSample && (curIdx == LAST);

  always_comb begin
    ctl           = '0;
    ctl.capture   = takeSample;
    ctl.writeIdx  = curIdx;
    ctl.blockLoad = lastSample;
    ctl.blockInv  = curInv;
    ctl.resLoad   = resLoadQ;
    ctl.cmpInv    = cmpInv;
    ctl.outValid  = outActive;
    ctl.outInv    = outInv;
    ctl.outSel    = outCnt;
  end

  // input sequencer: restarted by a start strobe, halts after the last sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inActive <= 1'b0;
      inCnt    <= '0;
      curInv   <= 1'b0;
    end else if (blkStartIn) begin
      inActive <= 1'b1;
      inCnt    <= IDX_W'(1);
      curInv   <= invModeIn;
    end else if (inActive) begin
      if (inCnt == LAST) inActive <= 1'b0;
      inCnt <= inCnt + 1'b1;
    end
  end

  // compute stage and output sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resLoadQ  <= 1'b0;
      cmpInv    <= 1'b0;
      outInv    <= 1'b0;
      outActive <= 1'b0;
      outCnt    <= '0;
    end else begin
      resLoadQ <= lastSample;
      if (lastSample) cmpInv <= curInv;
      if (resLoadQ) begin
        outInv    <= cmpInv;
        outActive <= 1'b1;
        outCnt    <= '0;
      end else if (outActive) begin
        if (outCnt == LAST) outActive <= 1'b0;
        outCnt <= outCnt + 1'b1;
      end
    end
  end

  assign validOut    = outActive;
  assign blkStartOut = outActive && (outCnt == '0);

  // R3: direction only changes on a start strobe
  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !blkStartIn |=> $stable(curInv));
  // R6: start pulse only with a valid result
  assert_start_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    blkStartOut |-> validOut);
  // R5: a result run always opens with the start pulse
  assert_run_opens_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validOut) |-> blkStartOut);
  // R5: results inside a run are contiguous
  assert_run_contig_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !blkStartOut) |-> $past(validOut));
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PIX_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dctCtl_t           ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int ACC_W = DATA_W + FRAC_W + 6;
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] HI_F  = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO_F  = -ACC_W'(1 << (DATA_W - 1));
  localparam logic signed [ACC_W-1:0] HI_I  = ACC_W'((1 << (PIX_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO_I  = -ACC_W'(1 << (PIX_W - 1));
  localparam logic signed [ACC_W-1:0] K1 = ACC_W'(cosTap(1, FRAC_W));
  localparam logic signed [ACC_W-1:0] K2 = ACC_W'(cosTap(2, FRAC_W));
  localparam logic signed [ACC_W-1:0] K3 = ACC_W'(cosTap(3, FRAC_W));
  localparam logic signed [ACC_W-1:0] K4 = ACC_W'(cosTap(4, FRAC_W));
  localparam logic signed [ACC_W-1:0] K5 = ACC_W'(cosTap(5, FRAC_W));
  localparam logic signed [ACC_W-1:0] K6 = ACC_W'(cosTap(6, FRAC_W));
  localparam logic signed [ACC_W-1:0] K7 = ACC_W'(cosTap(7, FRAC_W));

  logic        [DATA_W-1:0] sampleReg [NPTS-1];
  logic signed [DATA_W-1:0] blockReg  [NPTS];
  logic signed [DATA_W-1:0] resReg    [NPTS];
  logic signed [ACC_W-1:0]  v [NPTS];
  logic signed [ACC_W-1:0]  fw [NPTS];
  logic signed [ACC_W-1:0]  iv [NPTS];
  logic signed [ACC_W-1:0]  s [4], d [4], e [4], o [4];
  logic signed [ACC_W-1:0]  a0, a1, b0, b1, t0, t1, u0, u1;

  // forward pixels use only the low PIX_W bits; coefficients use all bits
  function automatic logic signed [DATA_W-1:0] extend(input logic [DATA_W-1:0] raw,
                                                       input logic inv);
    logic signed [PIX_W-1:0] pix;
    pix = raw[PIX_W-1:0];
    return inv ? $signed(raw) : DATA_W'(pix);
  endfunction

  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [ACC_W-1:0] acc,
                                                         input logic inv);
    logic signed [ACC_W-1:0] r;
    r = (acc + HALF) >>> FRAC_W;
    if (inv) r = (r > HI_I) ? HI_I : ((r < LO_I) ? LO_I : r);
    else     r = (r > HI_F) ? HI_F : ((r < LO_F) ? LO_F : r);
    return DATA_W'(r);
  endfunction

  genvar g;
  generate
    for (g = 0; g < NPTS; g++) begin : gLane
      if (g < NPTS - 1) begin : gStore
        always_ff @(posedge clk)
          if (ctl.capture && ctl.writeIdx == IDX_W'(g)) sampleReg[g] <= dataIn;
        always_ff @(posedge clk)
          if (ctl.blockLoad) blockReg[g] <= extend(sampleReg[g], ctl.blockInv);
      end else begin : gLast
        always_ff @(posedge clk)
          if (ctl.blockLoad) blockReg[g] <= extend(dataIn, ctl.blockInv);
      end
      assign v[g] = ACC_W'(blockReg[g]);
      always_ff @(posedge clk)
        if (ctl.resLoad) resReg[g] <= roundSat(ctl.cmpInv ? iv[g] : fw[g], ctl.cmpInv);
    end
  endgenerate

  // forward butterflies
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      s[i] = v[i] + v[NPTS-1-i];
      d[i] = v[i] - v[NPTS-1-i];
    end
    a0 = s[0] + s[3];  a1 = s[1] + s[2];
    b0 = s[0] - s[3];  b1 = s[1] - s[2];
    fw[0] = K4 * (a0 + a1);
    fw[4] = K4 * (a0 - a1);
    fw[2] = K2 * b0 + K6 * b1;
    fw[6] = K6 * b0 - K2 * b1;
    fw[1] = K1 * d[0] + K3 * d[1] + K5 * d[2] + K7 * d[3];
    fw[3] = K3 * d[0] - K7 * d[1] - K1 * d[2] - K5 * d[3];
    fw[5] = K5 * d[0] - K1 * d[1] + K7 * d[2] + K3 * d[3];
    fw[7] = K7 * d[0] - K5 * d[1] + K3 * d[2] - K1 * d[3];
  end

  // inverse butterflies (odd matrix is symmetric, reused transposed)
  always_comb begin
    t0 = K4 * (v[0] + v[4]);
    t1 = K4 * (v[0] - v[4]);
    u0 = K2 * v[2] + K6 * v[6];
    u1 = K6 * v[2] - K2 * v[6];
    e[0] = t0 + u0;  e[1] = t1 + u1;
    e[2] = t1 - u1;  e[3] = t0 - u0;
    o[0] = K1 * v[1] + K3 * v[3] + K5 * v[5] + K7 * v[7];
    o[1] = K3 * v[1] - K7 * v[3] - K1 * v[5] - K5 * v[7];
    o[2] = K5 * v[1] - K1 * v[3] + K7 * v[5] + K3 * v[7];
    o[3] = K7 * v[1] - K5 * v[3] + K3 * v[5] - K1 * v[7];
    for (int i = 0; i < 4; i++) begin
      iv[i]        = e[i] + o[i];
      iv[NPTS-1-i] = e[i] - o[i];
    end
  end

  assign dataOut = resReg[ctl.outSel];

  // R4: inverse results stay inside the pixel range
  assert_pix_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.outValid && ctl.outInv) |->
      ($signed(dataOut) <= $signed(HI_I[DATA_W-1:0]) &&
       $signed(dataOut) >= $signed(LO_I[DATA_W-1:0])));
endmodule

// File: rtl/dct1d_top.sv
module dct1d_top
  import dct_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PIX_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blkStartIn,
  input  logic              invModeIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              blkStartOut,
  output logic              validOut,
  output logic [DATA_W-1:0] dataOut
);
  dctCtl_t ctl;

  dct_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .blkStartIn  (blkStartIn),
    .invModeIn   (invModeIn),
    .ctl         (ctl),
    .blkStartOut (blkStartOut),
    .validOut    (validOut)
  );

  dct_datapath #(.DATA_W(DATA_W), .PIX_W(PIX_W), .FRAC_W(FRAC_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/dct1d_tb_top.sv
`timescale 1ns/1ps
module dct1d_tb_top;
  localparam int DATA_W = 12;
  localparam int PIX_W  = 9;
  localparam int TOL    = 2;
  localparam real PI    = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN, blkStartIn, invModeIn;
  logic [DATA_W-1:0] dataIn, dataOut;
  logic blkStartOut, validOut;

  always #2.5 clk = ~clk;

  dct1d_top #(.DATA_W(DATA_W), .PIX_W(PIX_W), .FRAC_W(12)) dut_i (.*);

  typedef struct { int cyc; int val; bit first; string tag; } expEnt_t;
  expEnt_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit running = 0, expV = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sx(input int raw, input int w);
    int m = raw & ((1 << w) - 1);
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  function automatic int refOut(input bit inv, input int v[8], input int k);
    real acc = 0.0;
    int r, lim;
    for (int n = 0; n < 8; n++) begin
      if (!inv) acc += ((k == 0) ? $sqrt(0.5) : 1.0) * 0.5 * v[n] * $cos((2*n+1)*k*PI/16.0);
      else      acc += ((n == 0) ? $sqrt(0.5) : 1.0) * 0.5 * v[n] * $cos((2*k+1)*n*PI/16.0);
    end
    r = $rtoi($floor(acc + 0.5));
    lim = inv ? (1 << (PIX_W - 1)) : (1 << (DATA_W - 1));
    if (r > lim - 1) r = lim - 1;
    if (r < -lim) r = -lim;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the reference queue
  always @(negedge clk) if (running) begin
    expV = (q.size() > 0) && (q[0].cyc == cyc);
    chk(validOut == expV, expV ? q[0].tag : "R9", int'(validOut), int'(expV));
    if (expV && validOut) begin
      chk(sx(int'(dataOut), DATA_W) - q[0].val <= TOL && q[0].val - sx(int'(dataOut), DATA_W) <= TOL,
          q[0].tag, sx(int'(dataOut), DATA_W), q[0].val);
      chk(blkStartOut == q[0].first, "R6", int'(blkStartOut), int'(q[0].first));
    end else if (!expV) begin
      chk(blkStartOut == 1'b0, "R6", int'(blkStartOut), 0);
    end
    while (q.size() > 0 && q[0].cyc <= cyc) void'(q.pop_front());
  end

  task automatic driveBlock(input bit inv, input int raw[8], input string tag, input bit flip);
    int v[8];
    int s = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      blkStartIn = (i == 0);
      invModeIn  = (i == 0) ? inv : (flip ? ~inv : inv);
      dataIn     = DATA_W'(raw[i]);
      if (i == 0) s = cyc;
      v[i] = inv ? sx(raw[i], DATA_W) : sx(raw[i], PIX_W);
    end
    for (int k = 0; k < 8; k++)
      q.push_back('{s + 9 + k, refOut(inv, v, k), k == 0, tag});
  endtask

  task automatic drivePartial(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      blkStartIn = (i == 0);
      invModeIn  = 1'b0;
      dataIn     = DATA_W'($urandom);
    end
  endtask

  task automatic driveIdle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      blkStartIn = 1'b0;
      invModeIn  = i[0];
      dataIn     = DATA_W'($urandom);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r[8];
    rstN = 1'b0; blkStartIn = 1'b0; invModeIn = 1'b0; dataIn = '0;
    repeat (4) @(negedge clk);
    chk(validOut == 1'b0 && blkStartOut == 1'b0, "R1", int'(validOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(validOut == 1'b0 && blkStartOut == 1'b0, "R1", int'(blkStartOut), 0);
    running = 1'b1;

    // R2: forward ramp
    r = '{-200, -120, -40, 0, 40, 100, 180, 255};
    driveBlock(1'b0, r, "R2", 1'b0);
    // R2: forward with garbage above the pixel width, back to back (R7)
    for (int i = 0; i < 8; i++) r[i] = int'($urandom & 32'hE00) | ((i * 61 - 256) & 32'h1FF);
    driveBlock(1'b0, r, "R7", 1'b0);
    // R4: inverse DC only, mode toggled after the start (R3)
    r = '{400, 0, 0, 0, 0, 0, 0, 0};
    driveBlock(1'b1, r, "R3", 1'b1);
    // R4: inverse mixed
    r = '{-300, 120, -80, 60, 0, -40, 25, -10};
    driveBlock(1'b1, r, "R4", 1'b0);
    // R4: inverse saturation both ways
    r = '{2000, 0, 0, 0, 0, 0, 0, 0};
    driveBlock(1'b1, r, "R4", 1'b0);
    r = '{-2000, 0, 0, 0, 0, 0, 0, 0};
    driveBlock(1'b1, r, "R4", 1'b0);
    // R3: forward group with mode toggled
    r = '{10, -20, 30, -40, 50, -60, 70, -80};
    driveBlock(1'b0, r, "R3", 1'b1);
    // R9: trailing samples with no start strobe
    driveIdle(12);
    // R8: abandoned partial group, then full group
    drivePartial(3);
    r = '{255, 255, 255, 255, -256, -256, -256, -256};
    driveBlock(1'b0, r, "R8", 1'b0);
    drivePartial(7);
    r = '{5, 0, -7, 0, 3, 0, 0, 1};
    driveBlock(1'b1, r, "R8", 1'b0);
    // mixed back-to-back groups
    for (int b = 0; b < 8; b++) begin
      bit inv = b[0] ^ b[2];
      for (int i = 0; i < 8; i++)
        r[i] = inv ? (int'($urandom % 601) - 300) : int'($urandom);
      driveBlock(inv, r, inv ? "R4" : "R2", 1'b0);
    end
    driveIdle(24);
    chk(q.size() == 0, "R5", q.size(), 0);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule